// File: doc/BRIEF.md
# Low Duty Cycle Receive Controller

This controller cuts a receiver's average power by switching it between sleep and listen intervals. Software sets it up through a 16-bit command port. One word sets the listen length D and the enable. Two further words set the 14-bit cycle length M. A free-running base tick sets the time unit. Each cycle of M ticks starts with a sleep interval and ends with a listen window of 2·D+1 ticks, during which the receiver-enable output is high.

When the data-quality input goes high on a tick inside a listen window, the controller latches a receive-hold state. The receiver then stays on, with the cycle counter frozen, until a tick arrives with the FIFO drained, no interrupt pending and data quality low. The controller then starts over with a full sleep interval.

While low duty cycle operation is disabled, the counter runs as a plain wake-up timer. It raises a one-clock wake-up interrupt at the end of each period and keeps the receiver off.

Top module: `ldc_rx_ctrl`

## Requirements
- R1: After reset, rx_en and wake_irq are 0 and state_o is 0. The state encoding is 0 = off, 1 = sleep, 2 = listen, 3 = hold. The duty settings reset to D = 7 with the mode disabled, and the period resets to M = 32.
- R2: A write whose bits 15:8 equal CCh is the duty command. Bits 7:1 give D and bit 0 enables the mode. Every such write restarts the cycle counter at 0, which is the start of a sleep interval, and clears the hold state.
- R3: A write with bits 15:8 = C3h loads M[13:8] from bits 5:0; bits 7:6 of that word are ignored. A write with bits 15:8 = E0h loads M[7:0] from bits 7:0. An M of 0 behaves as 1. Period writes do not restart the counter.
- R4: While enabled, and counting one position per tick from the restart, rx_en is low for the first M-(2D+1) positions of each cycle and high for the last 2D+1 positions.
- R5: When 2D+1 is at least M, rx_en is high on every position of the cycle, and the counter still wraps every M ticks.
- R6: While disabled, wake_irq is high for exactly one clock after the tick that ends each period. While enabled, wake_irq stays low.
- R7: A duty command with bit 0 clear drives rx_en low and state_o to 0 on the next clock.
- R8: A tick with dqd high during a listen window enters hold (state 3). The receiver stays on and the counter stays frozen. A tick with dqd high during a sleep interval has no effect.
- R9: Hold ends only on a tick with fifo_empty high, irq_pending low and dqd low. The next listen window then follows a full sleep interval of M-(2D+1) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe, one clock per word |
| cmd_word | input | 16 | Command word |
| tick | input | 1 | Base timing tick, one clock wide |
| dqd | input | 1 | Data quality good indication |
| fifo_empty | input | 1 | Receive FIFO is empty |
| irq_pending | input | 1 | Some interrupt is still pending |
| rx_en | output | 1 | Receiver enable |
| wake_irq | output | 1 | Wake-up timer interrupt pulse (mode disabled only) |
| state_o | output | 2 | 0 off, 1 sleep, 2 listen, 3 hold |

## Verification
A table walks the main sleep/listen sequence across several (D, M) pairs. It includes a short window, a window exactly equal to the period, a window longer than the period, M = 0, and a multi-byte M written with the ignored bits set. For each pair it counts the enabled positions and finds where the first one falls. A miscomputed window length shows up in the count. A reversed sleep/listen order or a wrong period assembly shows up in the first position. Directed sequences then use data quality first in sleep and then in listen. They hold the FIFO non-empty and then an interrupt pending, to show that each release condition is needed on its own. They also check the default period and the interrupt pulse in the disabled mode.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

   localparam logic [7:0] DUTY_PREFIX  = 8'hCC;
   localparam logic [7:0] M_HI_PREFIX  = 8'hC3;
   localparam logic [7:0] M_LO_PREFIX  = 8'hE0;

   typedef enum logic [1:0] {
      ST_OFF    = 2'd0,
      ST_SLEEP  = 2'd1,
      ST_LISTEN = 2'd2,
      ST_HOLD   = 2'd3
   } ldc_state_e;

endpackage

// File: rtl/ldc_cmd_regs.sv
module ldc_cmd_regs
   import ldc_pkg::*;
#(
   parameter int D_W      = 7,
   parameter int M_HI_W   = 6,
   parameter int M_LO_W   = 8,
   parameter int D_RST    = 7,
   parameter int M_HI_RST = 0,
   parameter int M_LO_RST = 32,
   localparam int M_W     = M_HI_W + M_LO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [15:0]      cmd_word,
   output logic [D_W-1:0]   d_val,
   output logic             ldc_en,
   output logic [M_W-1:0]   m_val,
   output logic             duty_wr
);

   logic             hi_wr;
   logic             lo_wr;
   logic [M_HI_W-1:0] m_hi_q;
   logic [M_LO_W-1:0] m_lo_q;

   assign duty_wr = cmd_wr && (cmd_word[15:8] == DUTY_PREFIX);
   assign hi_wr   = cmd_wr && (cmd_word[15:8] == M_HI_PREFIX);
   assign lo_wr   = cmd_wr && (cmd_word[15:8] == M_LO_PREFIX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         d_val  <= D_W'(D_RST);
         ldc_en <= 1'b0;
      end else if (duty_wr) begin
         d_val  <= cmd_word[D_W:1];
         ldc_en <= cmd_word[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_hi_q <= M_HI_W'(M_HI_RST);
      end else if (hi_wr) begin
         m_hi_q <= cmd_word[M_HI_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_lo_q <= M_LO_W'(M_LO_RST);
      end else if (lo_wr) begin
         m_lo_q <= cmd_word[M_LO_W-1:0];
      end
   end

   assign m_val = {m_hi_q, m_lo_q};

endmodule

// File: rtl/ldc_window_calc.sv
module ldc_window_calc #(
   parameter int D_W = 7,
   parameter int M_W = 14,
   localparam int ON_W = 2 * 1 + D_W - 1
) (
   input  logic [D_W-1:0] d_val,
   input  logic [M_W-1:0] m_val,
   output logic [M_W-1:0] m_eff,
   output logic [M_W-1:0] sleep_len
);

   logic [ON_W-1:0] on_len;
   logic [M_W-1:0]  on_ext;

   if (M_W < ON_W) begin : g_bad_widths
      $error("period width must hold the on-time width");
   end

   assign on_len = {d_val, 1'b1};
   assign on_ext = M_W'(on_len);
   assign m_eff  = (m_val == '0) ? M_W'(1) : m_val;

   always_comb begin
      if (on_ext >= m_eff) sleep_len = '0;
      else                 sleep_len = m_eff - on_ext;
   end

endmodule

// File: rtl/ldc_cycle_fsm.sv
module ldc_cycle_fsm #(
   parameter int M_W = 14
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic           dqd,
   input  logic           fifo_empty,
   input  logic           irq_pending,
   input  logic           duty_wr,
   input  logic           ldc_en,
   input  logic [M_W-1:0] m_eff,
   input  logic [M_W-1:0] sleep_len,
   output logic           hold,
   output logic           listen,
   output logic           wake_pulse
);

   logic [M_W-1:0] cnt_q;
   logic           wrap;
   logic           release_ok;

   assign wrap       = cnt_q >= (m_eff - M_W'(1));
   assign listen     = cnt_q >= sleep_len;
   assign release_ok = fifo_empty && !irq_pending && !dqd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         hold       <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= 1'b0;
         if (duty_wr) begin
            cnt_q <= '0;
            hold  <= 1'b0;
         end else if (tick) begin
            if (hold) begin
               if (release_ok) begin
                  hold  <= 1'b0;
                  cnt_q <= '0;
               end
            end else if (ldc_en && listen && dqd) begin
               hold <= 1'b1;
            end else begin
               cnt_q      <= wrap ? '0 : cnt_q + M_W'(1);
               wake_pulse <= !ldc_en && wrap;
            end
         end
      end
   end

endmodule

// File: rtl/ldc_rx_ctrl.sv
module ldc_rx_ctrl
   import ldc_pkg::*;
#(
   parameter int D_W      = 7,
   parameter int M_HI_W   = 6,
   parameter int M_LO_W   = 8,
   parameter int D_RST    = 7,
   parameter int M_HI_RST = 0,
   parameter int M_LO_RST = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [15:0] cmd_word,
   input  logic        tick,
   input  logic        dqd,
   input  logic        fifo_empty,
   input  logic        irq_pending,
   output logic        rx_en,
   output logic        wake_irq,
   output logic [1:0]  state_o
);

   localparam int M_W = M_HI_W + M_LO_W;

   if (D_W < 1 || D_W > 7) begin : g_bad_d_w
      $error("D field must be 1 to 7 bits");
   end
   if (M_HI_W < 1 || M_HI_W > 6) begin : g_bad_m_hi_w
      $error("upper period field must be 1 to 6 bits");
   end
   if (M_LO_W < 1 || M_LO_W > 8) begin : g_bad_m_lo_w
      $error("lower period field must be 1 to 8 bits");
   end
   if (D_RST >= (1 << D_W)) begin : g_bad_d_rst
      $error("D reset value does not fit its field");
   end

   logic [D_W-1:0] d_val;
   logic           ldc_en;
   logic [M_W-1:0] m_val;
   logic           duty_wr;
   logic [M_W-1:0] m_eff;
   logic [M_W-1:0] sleep_len;
   logic           hold;
   logic           listen;
   logic           wake_pulse;
   ldc_state_e     st;

   ldc_cmd_regs #(
      .D_W(D_W), .M_HI_W(M_HI_W), .M_LO_W(M_LO_W),
      .D_RST(D_RST), .M_HI_RST(M_HI_RST), .M_LO_RST(M_LO_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .d_val(d_val), .ldc_en(ldc_en), .m_val(m_val), .duty_wr(duty_wr)
   );

   ldc_window_calc #(.D_W(D_W), .M_W(M_W)) u_calc (
      .d_val(d_val), .m_val(m_val), .m_eff(m_eff), .sleep_len(sleep_len)
   );

   ldc_cycle_fsm #(.M_W(M_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .dqd(dqd),
      .fifo_empty(fifo_empty), .irq_pending(irq_pending),
      .duty_wr(duty_wr), .ldc_en(ldc_en), .m_eff(m_eff),
      .sleep_len(sleep_len), .hold(hold), .listen(listen),
      .wake_pulse(wake_pulse)
   );

   always_comb begin
      if (hold)         st = ST_HOLD;
      else if (!ldc_en) st = ST_OFF;
      else if (listen)  st = ST_LISTEN;
      else              st = ST_SLEEP;
   end

   assign state_o  = st;
   assign rx_en    = (st == ST_HOLD) || (st == ST_LISTEN);
   assign wake_irq = wake_pulse;

endmodule

// File: rtl/ldc_rx_ctrl_chk.sv
module ldc_rx_ctrl_chk
   import ldc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_wr,
   input logic [15:0] cmd_word,
   input logic        tick,
   input logic        dqd,
   input logic        fifo_empty,
   input logic        irq_pending,
   input logic        rx_en,
   input logic        wake_irq,
   input logic [1:0]  state_o
);

   logic duty_cmd;
   assign duty_cmd = cmd_wr && (cmd_word[15:8] == DUTY_PREFIX);

   AST_DUTY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      duty_cmd && cmd_word[0] |=> (state_o == ST_SLEEP || state_o == ST_LISTEN)); // R2

   AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      duty_cmd && !cmd_word[0] |=> !rx_en && state_o == ST_OFF); // R7

   AST_WAKE_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> state_o == ST_OFF); // R6

   AST_SLEEP_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_SLEEP && !cmd_wr |=> state_o != ST_HOLD); // R8

   AST_DQD_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      rx_en && dqd && tick && !cmd_wr |=> rx_en); // R8

   AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_HOLD && !cmd_wr && !(fifo_empty && !irq_pending && !dqd)
      |=> state_o == ST_HOLD); // R9

   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == ST_HOLD && !cmd_wr && tick && fifo_empty && !irq_pending && !dqd
      |=> state_o != ST_HOLD); // R9

endmodule

bind ldc_rx_ctrl ldc_rx_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
   .tick(tick), .dqd(dqd), .fifo_empty(fifo_empty),
   .irq_pending(irq_pending), .rx_en(rx_en), .wake_irq(wake_irq),
   .state_o(state_o)
);

// File: tb/ldc_rx_ctrl_tb.sv
`timescale 1ns/100ps
module ldc_rx_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        tick = 1'b0;
   logic        dqd = 1'b0;
   logic        fifo_empty = 1'b1;
   logic        irq_pending = 1'b0;
   logic        rx_en;
   logic        wake_irq;
   logic [1:0]  state_o;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   bit irq_seen;

   always #2.5 clk = ~clk;

   ldc_rx_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
      .tick(tick), .dqd(dqd), .fifo_empty(fifo_empty),
      .irq_pending(irq_pending), .rx_en(rx_en), .wake_irq(wake_irq),
      .state_o(state_o)
   );

   // vector table: D, M, expected enabled positions, expected first enabled position
   localparam int NV = 7;
   localparam int VD[NV]     = '{7, 0, 3, 20, 1, 127, 2};
   localparam int VM[NV]     = '{32, 10, 7, 5, 0, 300, 6};
   localparam int VON[NV]    = '{15, 1, 7, 5, 1, 255, 5};
   localparam int VFIRST[NV] = '{17, 9, 0, 0, 0, 45, 1};

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] w);
      @(negedge clk);
      cmd_wr = 1'b1;
      cmd_word = w;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      irq_seen = wake_irq;
   endtask

   task automatic set_m(input int m);
      wr({8'hC3, 2'b11, 6'(m >> 8)});
      wr({8'hE0, 8'(m)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int irq_cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rx_en", rx_en, 0);
      chk("R1 wake_irq", wake_irq, 0);
      chk("R1 state", state_o, 0);

      // R1 default period 32 observed through the disabled-mode timer
      irq_cnt = 0;
      for (int i = 0; i < 31; i++) begin
         do_tick();
         irq_cnt += irq_seen;
      end
      chk("R1 no irq before tick 32", irq_cnt, 0);
      do_tick();
      chk("R1 irq on tick 32", irq_seen, 1);

      // R6 M = 5 in disabled mode; counter at 0 after wrap
      set_m(5);
      irq_cnt = 0;
      for (int i = 0; i < 4; i++) begin
         do_tick();
         irq_cnt += irq_seen;
      end
      chk("R6 no irq mid period", irq_cnt, 0);
      do_tick();
      chk("R6 irq at period end", irq_seen, 1);
      @(negedge clk);
      chk("R6 irq one clock", wake_irq, 0);
      chk("R6 rx off while disabled", rx_en, 0);

      // R2 R3 R4 R5 table walk
      for (int v = 0; v < NV; v++) begin
         int on_cnt;
         int first;
         int meff;
         meff = (VM[v] == 0) ? 1 : VM[v];
         set_m(VM[v]);
         wr({8'hCC, 7'(VD[v]), 1'b1});
         on_cnt = 0;
         first = -1;
         irq_cnt = 0;
         for (int p = 0; p < meff; p++) begin
            if (rx_en) begin
               on_cnt++;
               if (first < 0) first = p;
            end
            do_tick();
            irq_cnt += irq_seen;
         end
         chk("R4 R5 enabled positions", on_cnt, VON[v]);
         chk("R2 R3 R4 first enabled position", first, VFIRST[v]);
         chk("R6 no irq while enabled", irq_cnt, 0);
         // after M ticks the counter has wrapped back to position 0
         chk("R5 wrap to cycle start", rx_en, (VFIRST[v] == 0) ? 1 : 0);
      end

      // R7 disable while listening at full duty
      set_m(5);
      wr(16'hCC29);
      chk("R7 listening before disable", rx_en, 1);
      wr(16'hCC28);
      chk("R7 rx_en after disable", rx_en, 0);
      chk("R7 state after disable", state_o, 0);

      // R8 R9 hold sequence: D=1 (on 3), M=10, sleep 7
      set_m(10);
      wr(16'hCC03);
      chk("R2 starts in sleep", state_o, 1);
      dqd = 1'b1;
      for (int i = 0; i < 3; i++) do_tick();
      chk("R8 dqd in sleep ignored", state_o, 1);
      dqd = 1'b0;
      for (int i = 0; i < 4; i++) do_tick();
      chk("R4 listen at position 7", state_o, 2);
      dqd = 1'b1;
      do_tick();
      chk("R8 hold entered", state_o, 3);
      chk("R8 rx on in hold", rx_en, 1);
      dqd = 1'b0;
      fifo_empty = 1'b0;
      for (int i = 0; i < 12; i++) do_tick();
      chk("R9 hold while fifo not empty", state_o, 3);
      fifo_empty = 1'b1;
      irq_pending = 1'b1;
      do_tick();
      chk("R9 hold while irq pending", state_o, 3);
      irq_pending = 1'b0;
      dqd = 1'b1;
      do_tick();
      chk("R9 hold while dqd high", state_o, 3);
      dqd = 1'b0;
      do_tick();
      chk("R9 hold released", state_o, 1);
      chk("R9 rx off after release", rx_en, 0);
      for (int i = 0; i < 6; i++) do_tick();
      chk("R9 still sleeping at position 6", rx_en, 0);
      do_tick();
      chk("R9 listen after full sleep", rx_en, 1);

      // R2 duty write clears hold
      dqd = 1'b1;
      do_tick();
      chk("R8 hold re-entered", state_o, 3);
      dqd = 1'b0;
      fifo_empty = 1'b0;
      wr(16'hCC03);
      chk("R2 duty write clears hold", state_o, 1);
      fifo_empty = 1'b1;

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule